// File: doc/BRIEF.md
# MDIO Management Frame Controller

This block is the master side of a clause-22 management link to an external PHY. Software writes one 32-bit command word, and the block sends a complete management frame on MDC/MDIO. The frame is a 32-bit preamble, start code, opcode, PHY and register addresses, turnaround and 16 data bits. For a read, the block releases MDIO during the turnaround and data bits and samples the PHY's reply on the rising MDC edges. The 16 captured bits then replace the low half of the command register. An `idle` output goes low for the whole frame, so software can poll for completion.

MDC is made from the system clock. A 2-bit configuration value selects one of four fixed ratios: 8, 16, 32 or 64. Software keeps MDC at or below 2.5 MHz by choosing 64 above 80 MHz, 32 above 40 MHz, 16 above 20 MHz, and 8 otherwise. A separate port-enable input gates all activity. While it is low, commands are refused, MDC stays low, and a frame in flight is abandoned.

The controller is a five-state machine:
- IDLE: waiting for a command.
- PREAMBLE: bits 0 to 31.
- HEADER: bits 32 to 45, covering start, opcode and the two addresses.
- TURN: bits 46 and 47.
- DATA: bits 48 to 63.

Transitions:
- IDLE to PREAMBLE on an accepted command.
- PREAMBLE to HEADER, HEADER to TURN and TURN to DATA, each on the MDC fall that ends the last bit of the phase.
- DATA to IDLE on the MDC fall that ends bit 63.
- Any state to IDLE when port-enable is low.

Top module: `mdio_master`

## Requirements
- R1: After reset, `idle` is 1, `mdc` is 0, `mdio_oe` is 0 and `cmd_rdata` is 0.
- R2: A command is accepted only when `cmd_wr` is high while `idle` is 1 and `port_en` is 1. A `cmd_wr` pulse during a frame is ignored: the frame on the wire and the final register contents are those of the first command.
- R3: While `port_en` is 0, `cmd_wr` has no effect and `mdc` stays 0. Dropping `port_en` mid-frame returns `idle` to 1, `mdc` to 0 and `mdio_oe` to 0 on the next clock edge.
- R4: `div_sel` values 0, 1, 2 and 3 give an MDC period of 8, 16, 32 and 64 system clocks. The value is latched at acceptance. MDC rises first one half period after the acceptance edge and toggles every half period after that.
- R5: Command word fields are bit 28 (1 = read, 0 = write), bits 27:23 (PHY address), bits 22:18 (register address) and bits 15:0 (write data). Other bits are stored but not sent. A write frame is 32 ones, 01, 01, PHY address, register address, 10 and the 16 data bits, each field MSB first.
- R6: A read frame drives 32 ones, 01, 10, PHY address and register address (46 bits). `mdio_oe` is low for bits 46 to 63, and `mdio_i` is sampled at each rising MDC edge of bits 48 to 63, MSB first.
- R7: When a read completes, `cmd_rdata[15:0]` holds the captured data and `cmd_rdata[31:16]` keeps the command. After a write, `cmd_rdata` equals the command word.
- R8: `idle` is 0 for exactly 64 MDC periods, counted from the acceptance edge, and is 1 otherwise.
- R9: A read from an absent PHY, with MDIO held high by the pull-up, returns 16'hFFFF.
- R10: Within a frame, `mdio_o` changes only at a clock edge where `mdc` falls.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| port_en | input | 1 | Management port enable; gates all activity |
| div_sel | input | 2 | MDC divider select (8/16/32/64) |
| cmd_wr | input | 1 | Command register write strobe |
| cmd_wdata | input | 32 | Command word |
| cmd_rdata | output | 32 | Command register, read data in the low half |
| idle | output | 1 | High when no frame is in progress |
| mdc | output | 1 | Management clock |
| mdio_o | output | 1 | MDIO output value |
| mdio_oe | output | 1 | MDIO output enable |
| mdio_i | input | 1 | MDIO input value |

## Verification
Suppose the bit counter or the phase state goes wrong. It shows at the ports within one MDC period, as a misplaced `mdio_oe` release, a shifted field in the frame the PHY model collects, or `idle` rising early or late against the cycle model. A divider fault changes the `mdc` level within half an MDC period, and the per-clock comparison catches it there. A capture or load fault appears only when the frame completes, as a wrong low half in `cmd_rdata`. An accept or abort fault appears as a changed upper half of the register, or as `mdc` toggling after port-enable drops.

// File: rtl/mdio_pkg.sv
package mdio_pkg;
    localparam int FRAME_BITS = 64;
    localparam int CMD_W      = 32;
    localparam int DATA_W     = 16;
    localparam int RD_BIT     = 28;
    localparam int PHY_LSB    = 23;
    localparam int REG_LSB    = 18;
    localparam int HDR_FIRST  = 32;
    localparam int TURN_FIRST = 46;
    localparam int DATA_FIRST = 48;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_PRE,
        ST_HDR,
        ST_TURN,
        ST_DATA
    } mdio_state_t;

    function automatic mdio_state_t phase_of(input logic [5:0] b);
        if (int'(b) < HDR_FIRST)       return ST_PRE;
        else if (int'(b) < TURN_FIRST) return ST_HDR;
        else if (int'(b) < DATA_FIRST) return ST_TURN;
        else                           return ST_DATA;
    endfunction
endpackage

// File: rtl/mdio_clkgen.sv
module mdio_clkgen #(
    parameter int DIV_LOG2_MIN = 3,
    localparam int CW = DIV_LOG2_MIN + 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       run,
    input  logic [1:0] sel,
    output logic       mdc,
    output logic       rise_tk,
    output logic       fall_tk
);
    logic [CW-1:0] cnt_q;
    logic [CW-1:0] half_m1;
    logic          mdc_q;
    logic          wrap;

    always_comb begin
        half_m1 = CW'((1 << (DIV_LOG2_MIN - 1 + int'(sel))) - 1);
        wrap    = run && (cnt_q == half_m1);
        rise_tk = wrap && !mdc_q;
        fall_tk = wrap && mdc_q;
        mdc     = mdc_q;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
            mdc_q <= 1'b0;
        end else if (!run) begin
            cnt_q <= '0;
            mdc_q <= 1'b0;
        end else if (wrap) begin
            cnt_q <= '0;
            mdc_q <= ~mdc_q;
        end else begin
            cnt_q <= cnt_q + 1'b1;
        end
    end
endmodule

// File: rtl/mdio_rx_capture.sv
module mdio_rx_capture #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         shift_en,
    input  logic         din,
    output logic [W-1:0] word
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)        word <= '0;
        else if (shift_en) word <= {word[W-2:0], din};
    end
endmodule

// File: rtl/mdio_master.sv
module mdio_master
    import mdio_pkg::*;
#(
    parameter int DIV_LOG2_MIN = 3
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        port_en,
    input  logic [1:0]  div_sel,
    input  logic        cmd_wr,
    input  logic [31:0] cmd_wdata,
    output logic [31:0] cmd_rdata,
    output logic        idle,
    output logic        mdc,
    output logic        mdio_o,
    output logic        mdio_oe,
    input  logic        mdio_i
);
    localparam int BW = $clog2(FRAME_BITS);

    mdio_state_t       state_q, state_d;
    logic [BW-1:0]     bit_q;
    logic [CMD_W-1:0]  cmd_q;
    logic [1:0]        sel_q;
    logic [FRAME_BITS-1:0] frame;
    logic [DATA_W-1:0] rx_word;
    logic              start, run, is_rd, last_fall;
    logic              rise_tk, fall_tk;

    assign start     = cmd_wr && port_en && (state_q == ST_IDLE);
    assign run       = port_en && (state_q != ST_IDLE);
    assign is_rd     = cmd_q[RD_BIT];
    assign last_fall = fall_tk && (bit_q == BW'(FRAME_BITS - 1));
    assign frame     = {32'hFFFF_FFFF, 2'b01, (is_rd ? 2'b10 : 2'b01),
                        cmd_q[PHY_LSB +: 5], cmd_q[REG_LSB +: 5],
                        (is_rd ? 2'b11 : 2'b10), cmd_q[DATA_W-1:0]};

    mdio_clkgen #(.DIV_LOG2_MIN(DIV_LOG2_MIN)) u_clk (
        .clk(clk), .rst_n(rst_n), .run(run), .sel(sel_q),
        .mdc(mdc), .rise_tk(rise_tk), .fall_tk(fall_tk)
    );

    mdio_rx_capture #(.W(DATA_W)) u_rx (
        .clk(clk), .rst_n(rst_n),
        .shift_en(rise_tk && is_rd && (state_q == ST_DATA)),
        .din(mdio_i), .word(rx_word)
    );

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: if (start) state_d = ST_PRE;
            ST_PRE, ST_HDR, ST_TURN, ST_DATA: begin
                if (!port_en)       state_d = ST_IDLE;
                else if (last_fall) state_d = ST_IDLE;
                else if (fall_tk)   state_d = phase_of(bit_q + 1'b1);
            end
            default: state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            bit_q   <= '0;
            cmd_q   <= '0;
            sel_q   <= '0;
        end else begin
            state_q <= state_d;
            if (start) begin
                bit_q <= '0;
                cmd_q <= cmd_wdata;
                sel_q <= div_sel;
            end else if (fall_tk) begin
                bit_q <= bit_q + 1'b1;
                if (last_fall && is_rd) cmd_q[DATA_W-1:0] <= rx_word;
            end
        end
    end

    always_comb begin
        idle      = (state_q == ST_IDLE);
        cmd_rdata = cmd_q;
        mdio_o    = idle ? 1'b1 : frame[BW'(FRAME_BITS - 1) - bit_q];
        mdio_oe   = !idle && !(is_rd && (state_q == ST_TURN || state_q == ST_DATA));
    end
endmodule

// File: rtl/mdio_master_chk.sv
module mdio_master_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        port_en,
    input logic        idle,
    input logic        mdc,
    input logic        mdio_o,
    input logic        mdio_oe,
    input logic [31:0] cmd_rdata
);
    AST_PORT_OFF_STOPS: assert property (@(posedge clk) disable iff (!rst_n)
        !port_en |=> (!mdc && idle && !mdio_oe)); // R3
    AST_IDLE_NO_DRIVE: assert property (@(posedge clk) disable iff (!rst_n)
        idle |-> !mdio_oe); // R6
    AST_MDC_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        (idle && $past(idle)) |-> !mdc); // R4
    AST_OUT_ON_FALL: assert property (@(posedge clk) disable iff (!rst_n)
        (!idle && !$past(idle) && !($past(mdc) && !mdc)) |-> $stable(mdio_o)); // R10
    AST_CMD_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        (!idle && !$past(idle)) |-> $stable(cmd_rdata)); // R2
endmodule

bind mdio_master mdio_master_chk u_chk (
    .clk(clk), .rst_n(rst_n), .port_en(port_en), .idle(idle), .mdc(mdc),
    .mdio_o(mdio_o), .mdio_oe(mdio_oe), .cmd_rdata(cmd_rdata)
);

// File: tb/tb_mdio_master.sv
module tb_mdio_master;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        port_en = 1'b0;
    logic [1:0]  div_sel = 2'd0;
    logic        cmd_wr = 1'b0;
    logic [31:0] cmd_wdata = '0;
    logic [31:0] cmd_rdata;
    logic        idle, mdc, mdio_o, mdio_oe, mdio_i;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    // bench-side PHY
    bit          phy_present = 1'b1;
    logic [15:0] phy_data = 16'h0;
    int          rises = 0;
    logic [63:0] cap = '0;
    int          ncap = 0;

    // cycle reference model
    int ref_e = -1;
    int ref_ratio = 8;
    bit ref_rd = 1'b0;

    always #5 clk = ~clk;

    mdio_master dut (
        .clk(clk), .rst_n(rst_n), .port_en(port_en), .div_sel(div_sel),
        .cmd_wr(cmd_wr), .cmd_wdata(cmd_wdata), .cmd_rdata(cmd_rdata),
        .idle(idle), .mdc(mdc), .mdio_o(mdio_o), .mdio_oe(mdio_oe), .mdio_i(mdio_i)
    );

    assign mdio_i = (phy_present && ref_rd && rises >= 48 && rises < 64)
                    ? phy_data[63 - rises] : 1'b1;

    always @(posedge mdc) begin
        if (mdio_oe) begin
            cap  = {cap[62:0], mdio_o};
            ncap = ncap + 1;
        end
        rises = rises + 1;
    end

    task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
        end
    endtask

    always @(negedge clk) begin
        if (rst_n && !done) begin
            bit busy;
            int bitn;
            logic exp_mdc, exp_oe;
            busy    = (ref_e >= 0);
            bitn    = busy ? ref_e / ref_ratio : 0;
            exp_mdc = busy ? logic'(((ref_e / (ref_ratio / 2)) % 2) == 1) : 1'b0;
            exp_oe  = busy && !(ref_rd && bitn >= 46);
            chk(idle == !busy, "R8 idle", 64'(idle), 64'(!busy));
            chk(mdc == exp_mdc, "R4 mdc", 64'(mdc), 64'(exp_mdc));
            chk(mdio_oe == exp_oe, "R6 mdio_oe", 64'(mdio_oe), 64'(exp_oe));
            if (!port_en) ref_e = -1;
            else if (ref_e < 0) begin
                if (cmd_wr) begin
                    ref_e = 0;
                    ref_ratio = 8 << div_sel;
                    ref_rd = cmd_wdata[28];
                end
            end else begin
                ref_e++;
                if (ref_e == 64 * ref_ratio) ref_e = -1;
            end
        end
    end

    task automatic issue(input logic [31:0] c, input bit fresh);
        @(posedge clk); #1;
        if (fresh) begin
            rises = 0; ncap = 0; cap = '0;
        end
        cmd_wr = 1'b1; cmd_wdata = c;
        @(posedge clk); #1;
        cmd_wr = 1'b0;
    endtask

    task automatic wait_idle();
        for (int i = 0; i < 10000; i++) begin
            @(negedge clk);
            if (idle) break;
        end
        @(negedge clk);
    endtask

    function automatic logic [31:0] mk(input bit rd, input logic [4:0] phy, input logic [4:0] rg, input logic [15:0] d);
        return {3'b000, rd, phy, rg, 2'b00, d};
    endfunction

    initial begin
        int wd;
        for (wd = 0; wd < 150000 && !done; wd++) @(posedge clk);
        if (!done) begin
            fails++; checks++;
            $display("FAIL watchdog expired");
            done = 1'b1;
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

    initial begin
        logic [31:0] c;
        repeat (3) @(posedge clk);
        @(negedge clk);
        chk(idle && !mdc && !mdio_oe && cmd_rdata == 0, "R1 reset state",
            {cmd_rdata, 29'd0, idle, mdc, mdio_oe}, 64'h4);
        @(posedge clk); #1 rst_n = 1'b1; port_en = 1'b1;

        // R5 write frame, divide by 8
        div_sel = 2'd0;
        c = mk(1'b0, 5'h12, 5'h04, 16'hA5C3);
        issue(c, 1'b1); wait_idle();
        chk(ncap == 64, "R5 write bit count", 64'(ncap), 64'd64);
        chk(cap == {32'hFFFF_FFFF, 2'b01, 2'b01, 5'h12, 5'h04, 2'b10, 16'hA5C3},
            "R5 write frame", cap, {32'hFFFF_FFFF, 2'b01, 2'b01, 5'h12, 5'h04, 2'b10, 16'hA5C3});
        chk(cmd_rdata == c, "R7 write leaves register", 64'(cmd_rdata), 64'(c));

        // R6/R7 read from present PHY, divide by 16
        div_sel = 2'd1; phy_present = 1'b1; phy_data = 16'h3C5A;
        c = mk(1'b1, 5'h01, 5'h02, 16'h0000) | 32'h8000_0000;
        issue(c, 1'b1); wait_idle();
        chk(ncap == 46, "R6 driven bits on read", 64'(ncap), 64'd46);
        chk(cap[45:0] == {32'hFFFF_FFFF, 2'b01, 2'b10, 5'h01, 5'h02}, "R6 read header",
            64'(cap[45:0]), 64'({32'hFFFF_FFFF, 2'b01, 2'b10, 5'h01, 5'h02}));
        chk(cmd_rdata == {c[31:16], 16'h3C5A}, "R7 read data", 64'(cmd_rdata), 64'({c[31:16], 16'h3C5A}));

        // R9 absent PHY, divide by 32
        div_sel = 2'd2; phy_present = 1'b0;
        c = mk(1'b1, 5'h1F, 5'h1F, 16'h1234);
        issue(c, 1'b1); wait_idle();
        chk(cmd_rdata[15:0] == 16'hFFFF, "R9 absent PHY", 64'(cmd_rdata[15:0]), 64'hFFFF);

        // R2 command while busy ignored, divide by 64
        div_sel = 2'd3; phy_present = 1'b1;
        c = mk(1'b0, 5'h0A, 5'h15, 16'h0F0F);
        issue(c, 1'b1);
        repeat (300) @(posedge clk);
        issue(mk(1'b1, 5'h03, 5'h03, 16'hFFFF), 1'b0);
        wait_idle();
        chk(cmd_rdata == c, "R2 busy write ignored", 64'(cmd_rdata), 64'(c));
        chk(cap == {32'hFFFF_FFFF, 2'b01, 2'b01, 5'h0A, 5'h15, 2'b10, 16'h0F0F},
            "R2 frame of first command", cap, {32'hFFFF_FFFF, 2'b01, 2'b01, 5'h0A, 5'h15, 2'b10, 16'h0F0F});

        // R3 port disabled: write ignored
        div_sel = 2'd0; port_en = 1'b0;
        issue(mk(1'b0, 5'h05, 5'h05, 16'hBEEF), 1'b1);
        repeat (40) @(negedge clk);
        chk(idle && !mdc && rises == 0, "R3 disabled no activity", {idle, mdc, 62'(rises)}, 64'h8000_0000_0000_0000);
        chk(cmd_rdata == c, "R3 disabled register unchanged", 64'(cmd_rdata), 64'(c));

        // R3 abort mid-frame
        port_en = 1'b1;
        issue(mk(1'b0, 5'h06, 5'h07, 16'h1111), 1'b1);
        repeat (100) @(posedge clk);
        #1 port_en = 1'b0;
        @(posedge clk); @(negedge clk);
        chk(idle && !mdc && !mdio_oe, "R3 abort", {61'd0, idle, mdc, mdio_oe}, 64'h4);
        #1 port_en = 1'b1;
        repeat (20) @(negedge clk);
        chk(idle && !mdc, "R3 stays idle after abort", {62'd0, idle, mdc}, 64'h2);

        // R10 ordering covered by the bound assertion; short read at divide 8
        div_sel = 2'd0; phy_data = 16'h8001;
        c = mk(1'b1, 5'h10, 5'h01, 16'h0000);
        issue(c, 1'b1); wait_idle();
        chk(cmd_rdata[15:0] == 16'h8001, "R7 R10 edge bits read", 64'(cmd_rdata[15:0]), 64'h8001);

        done = 1'b1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule